// File: doc/BRIEF.md
# Multi-Ring DMA Controller Register Bank

This block is the software-visible register file of a network DMA engine that serves eight transmit rings and eight receive rings. A processor reaches it through 32-bit word accesses inside a 4 KB window. The word index is taken from byte-address bits [11:2], and the two lowest address bits are ignored. Each location follows one access policy: read-write, write-only, write-1-to-clear or read-only. Locations that are not mapped read as zero and ignore writes.

An event register collects interrupt causes. Software clears them and hardware sets them through a strobe vector. An enable register gates the events. The enabled set is split into three groups, each of which drives one interrupt line.

Two halt-status registers hold one halt flag per ring. Software clears a flag by writing 1 to it, and the same write also restarts the ring: a one-cycle kick pulse goes out to the descriptor engine. Transmit rings are kicked on every 1 written. Receive rings are kicked only when their flag was already clear.

Each ring has a base register. Writing it loads an 8-byte aligned address into the base register and also into that ring's live-pointer register.

Top module: `dma_ring_regs`

## Requirements
- R1: After reset, every stored register reads zero, the identity register reads ID_VALUE, and all kick and interrupt outputs are low.
- R2: Address bits [1:0] are ignored. Unmapped locations (for example byte 0x800) read zero and ignore writes. The map, by byte offset, is: 0x000 event, 0x004 enable, 0x008 identity, 0x00C command, 0x010 transmit halt, 0x014 receive halt, 0x100+4n transmit base n, 0x140+4n transmit pointer n, 0x180+4n receive base n, 0x1C0+4n receive pointer n.
- R3: The enable register (0x004) is read-write and reads back the last value written.
- R4: The command register (0x00C) is write-only. It always reads zero, and the last value written to it appears on cmd_word from the cycle after the write.
- R5: The identity register (0x008) is read-only. A write to it leaves its value ID_VALUE unchanged.
- R6: The event register (0x000) clears each bit written as 1. A bit set by evt_set in the same cycle as a software clear of that bit ends up set.
- R7: irq_tx, irq_rx and irq_err are each high exactly when (event AND enable) has a bit inside TX_GROUP (default 0x000000FF), RX_GROUP (default 0x0000FF00) or ERR_GROUP (default 0xFFFF0000) respectively. They follow register changes with no added delay.
- R8: In the transmit halt register, bit 31−i belongs to ring i. Writing 1 there drives tx_kick[i] high for exactly the one cycle after the write, whatever the flag's previous value.
- R9: In the receive halt register, bit 23−i belongs to ring i. Writing 1 there drives rx_kick[i] high for the one cycle after the write only if that flag was 0 before the write.
- R10: A halt flag is set by tx_halt_set[i] or rx_halt_set[i] and cleared by a 1 written to its bit. The other bits of the two halt registers read zero.
- R11: A write to base register n stores the data with bits [2:0] forced to zero, and loads the same value into pointer register n.
- R12: The pointer registers are read-only on the bus. A write to them is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for one word |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_set | input | 32 | Hardware event set strobes, one per event bit |
| tx_halt_set | input | NRING | Hardware set of transmit halt flags |
| rx_halt_set | input | NRING | Hardware set of receive halt flags |
| cmd_word | output | 32 | Contents of the write-only command register |
| tx_kick | output | NRING | One-cycle restart pulse per transmit ring |
| rx_kick | output | NRING | One-cycle restart pulse per receive ring |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The tests drive a single event bit into each interrupt group, first while it is masked and then while it is enabled, so that the enable gating and the group split are checked separately. A set and a clear of the same event bit in one cycle shows which of the two wins. The halt writes mix rings whose flag is set with rings whose flag is clear, and the same pattern is used on both directions; this separates the always-kick transmit rule from the kick-only-if-clear receive rule. Base writes carry low bits that must be dropped. Writes also go to the identity register, the pointer registers, an unmapped word and a misaligned address, and the read-back shows that each is ignored or aliased as required.

// File: rtl/dma_ring_regs_pkg.sv
package dma_ring_regs_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int WIDX_W   = ADDR_W - 2;
  localparam int BLK_W    = ADDR_W - 5;
  localparam int RING_IW  = 3;
  localparam int ALIGN_LO = 3;

  // bit of ring 0 in each halt register; ring i sits at MSB - i
  localparam int TX_HALT_MSB = 31;
  localparam int RX_HALT_MSB = 23;

  // single-word locations, as word indices
  localparam logic [WIDX_W-1:0] W_EVT  = 10'h000;
  localparam logic [WIDX_W-1:0] W_ENA  = 10'h001;
  localparam logic [WIDX_W-1:0] W_ID   = 10'h002;
  localparam logic [WIDX_W-1:0] W_CMD  = 10'h003;
  localparam logic [WIDX_W-1:0] W_TXH  = 10'h004;
  localparam logic [WIDX_W-1:0] W_RXH  = 10'h005;

  // eight-word ring blocks, indexed by address bits [11:5]
  localparam logic [BLK_W-1:0] B_TXBASE = 7'h08;
  localparam logic [BLK_W-1:0] B_TXPTR  = 7'h0A;
  localparam logic [BLK_W-1:0] B_RXBASE = 7'h0C;
  localparam logic [BLK_W-1:0] B_RXPTR  = 7'h0E;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_EVT,
    SEL_ENA,
    SEL_ID,
    SEL_CMD,
    SEL_TXH,
    SEL_RXH,
    SEL_TXBASE,
    SEL_TXPTR,
    SEL_RXBASE,
    SEL_RXPTR
  } sel_e;

endpackage

// File: rtl/dma_ring_decode.sv
module dma_ring_decode
  import dma_ring_regs_pkg::*;
#(
  parameter int NRING = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  output sel_e               sel,
  output logic [RING_IW-1:0] ring
);

  logic [WIDX_W-1:0] widx;
  logic [BLK_W-1:0]  blk;
  logic              ring_ok;
  logic              unused_lsb;

  assign widx       = addr[ADDR_W-1:2];
  assign blk        = addr[ADDR_W-1:5];
  assign ring       = addr[4:2];
  assign ring_ok    = (int'(ring) < NRING);
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    sel = SEL_NONE;
    unique case (widx)
      W_EVT:   sel = SEL_EVT;
      W_ENA:   sel = SEL_ENA;
      W_ID:    sel = SEL_ID;
      W_CMD:   sel = SEL_CMD;
      W_TXH:   sel = SEL_TXH;
      W_RXH:   sel = SEL_RXH;
      default: sel = SEL_NONE;
    endcase
    if (ring_ok) begin
      if      (blk == B_TXBASE) sel = SEL_TXBASE;
      else if (blk == B_TXPTR)  sel = SEL_TXPTR;
      else if (blk == B_RXBASE) sel = SEL_RXBASE;
      else if (blk == B_RXPTR)  sel = SEL_RXPTR;
    end
  end

endmodule

// File: rtl/dma_ring_events.sv
module dma_ring_events
  import dma_ring_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] TX_GROUP  = 32'h0000_00FF,
  parameter logic [DATA_W-1:0] RX_GROUP  = 32'h0000_FF00,
  parameter logic [DATA_W-1:0] ERR_GROUP = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              wr_ena,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] set_vec,
  output logic [DATA_W-1:0] evt_q,
  output logic [DATA_W-1:0] ena_q,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);

  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] evt_nxt;
  logic [DATA_W-1:0] live;

  // hardware set is applied after the software clear, so it wins
  always_comb begin
    clr_vec = wr_evt ? wdata : '0;
    evt_nxt = (evt_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (wr_ena) begin
      ena_q <= wdata;
    end
  end

  assign live    = evt_q & ena_q;
  assign irq_tx  = |(live & TX_GROUP);
  assign irq_rx  = |(live & RX_GROUP);
  assign irq_err = |(live & ERR_GROUP);

endmodule

// File: rtl/dma_ring_halt.sv
module dma_ring_halt #(
  parameter int NRING         = 8,
  parameter bit KICK_IF_CLEAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [NRING-1:0] wbits,
  input  logic [NRING-1:0] hw_set,
  output logic [NRING-1:0] halt_q,
  output logic [NRING-1:0] kick
);

  logic [NRING-1:0] clr;
  logic [NRING-1:0] gate;
  logic [NRING-1:0] halt_nxt;
  logic [NRING-1:0] kick_nxt;

  generate
    if (KICK_IF_CLEAR) begin : g_gated
      assign gate = ~halt_q;
    end else begin : g_always
      assign gate = '1;
    end
  endgenerate

  always_comb begin
    clr      = wr ? wbits : '0;
    halt_nxt = hw_set | (halt_q & ~clr);
    kick_nxt = clr & gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= '0;
      kick   <= '0;
    end else begin
      halt_q <= halt_nxt;
      kick   <= kick_nxt;
    end
  end

endmodule

// File: rtl/dma_ring_bases.sv
module dma_ring_bases
  import dma_ring_regs_pkg::*;
#(
  parameter int NRING = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_base,
  input  logic [RING_IW-1:0]            ring,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NRING-1:0][DATA_W-1:0]  base_q,
  output logic [NRING-1:0][DATA_W-1:0]  ptr_q
);

  logic [DATA_W-1:0] aligned;
  logic [NRING-1:0]  ring_en;
  logic              unused_low;

  assign aligned    = {wdata[DATA_W-1:ALIGN_LO], {ALIGN_LO{1'b0}}};
  assign unused_low = ^wdata[ALIGN_LO-1:0];

  generate
    for (genvar g = 0; g < NRING; g++) begin : g_en
      assign ring_en[g] = wr_base && (ring == RING_IW'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else begin
      for (int i = 0; i < NRING; i++) begin
        if (ring_en[i]) begin
          base_q[i] <= aligned;
          ptr_q[i]  <= aligned;
        end
      end
    end
  end

endmodule

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
  import dma_ring_regs_pkg::*;
#(
  parameter int                NRING     = 8,
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h5A10_0008,
  parameter logic [DATA_W-1:0] TX_GROUP  = 32'h0000_00FF,
  parameter logic [DATA_W-1:0] RX_GROUP  = 32'h0000_FF00,
  parameter logic [DATA_W-1:0] ERR_GROUP = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_set,
  input  logic [NRING-1:0]  tx_halt_set,
  input  logic [NRING-1:0]  rx_halt_set,
  output logic [31:0]       cmd_word,
  output logic [NRING-1:0]  tx_kick,
  output logic [NRING-1:0]  rx_kick,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  sel_e               sel;
  logic [RING_IW-1:0] ring;

  dma_ring_decode #(.NRING(NRING)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .ring (ring)
  );

  logic wr_evt, wr_ena, wr_cmd, wr_txh, wr_rxh, wr_txb, wr_rxb;
  assign wr_evt = bus_wr && (sel == SEL_EVT);
  assign wr_ena = bus_wr && (sel == SEL_ENA);
  assign wr_cmd = bus_wr && (sel == SEL_CMD);
  assign wr_txh = bus_wr && (sel == SEL_TXH);
  assign wr_rxh = bus_wr && (sel == SEL_RXH);
  assign wr_txb = bus_wr && (sel == SEL_TXBASE);
  assign wr_rxb = bus_wr && (sel == SEL_RXBASE);

  logic [DATA_W-1:0] evt_q, ena_q;

  dma_ring_events #(
    .TX_GROUP  (TX_GROUP),
    .RX_GROUP  (RX_GROUP),
    .ERR_GROUP (ERR_GROUP)
  ) u_evt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_evt  (wr_evt),
    .wr_ena  (wr_ena),
    .wdata   (bus_wdata),
    .set_vec (evt_set),
    .evt_q   (evt_q),
    .ena_q   (ena_q),
    .irq_tx  (irq_tx),
    .irq_rx  (irq_rx),
    .irq_err (irq_err)
  );

  // write-only command word
  logic [DATA_W-1:0] cmd_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q <= '0;
    end else if (wr_cmd) begin
      cmd_q <= bus_wdata;
    end
  end
  assign cmd_word = cmd_q;

  // halt fields, reordered so that ring i is bit i
  logic [NRING-1:0] tx_bits, rx_bits, tx_halt, rx_halt;
  generate
    for (genvar g = 0; g < NRING; g++) begin : g_field
      assign tx_bits[g] = bus_wdata[TX_HALT_MSB-g];
      assign rx_bits[g] = bus_wdata[RX_HALT_MSB-g];
    end
  endgenerate

  dma_ring_halt #(.NRING(NRING), .KICK_IF_CLEAR(1'b0)) u_txh (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr     (wr_txh),
    .wbits  (tx_bits),
    .hw_set (tx_halt_set),
    .halt_q (tx_halt),
    .kick   (tx_kick)
  );

  dma_ring_halt #(.NRING(NRING), .KICK_IF_CLEAR(1'b1)) u_rxh (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr     (wr_rxh),
    .wbits  (rx_bits),
    .hw_set (rx_halt_set),
    .halt_q (rx_halt),
    .kick   (rx_kick)
  );

  logic [NRING-1:0][DATA_W-1:0] tx_base, tx_ptr, rx_base, rx_ptr;

  dma_ring_bases #(.NRING(NRING)) u_txr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_base (wr_txb),
    .ring    (ring),
    .wdata   (bus_wdata),
    .base_q  (tx_base),
    .ptr_q   (tx_ptr)
  );

  dma_ring_bases #(.NRING(NRING)) u_rxr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_base (wr_rxb),
    .ring    (ring),
    .wdata   (bus_wdata),
    .base_q  (rx_base),
    .ptr_q   (rx_ptr)
  );

  // read path; the command word is write-only and reads as zero
  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_EVT:    bus_rdata = evt_q;
      SEL_ENA:    bus_rdata = ena_q;
      SEL_ID:     bus_rdata = ID_VALUE;
      SEL_TXH: begin
        for (int i = 0; i < NRING; i++) bus_rdata[TX_HALT_MSB-i] = tx_halt[i];
      end
      SEL_RXH: begin
        for (int i = 0; i < NRING; i++) bus_rdata[RX_HALT_MSB-i] = rx_halt[i];
      end
      SEL_TXBASE: bus_rdata = tx_base[ring];
      SEL_TXPTR:  bus_rdata = tx_ptr[ring];
      SEL_RXBASE: bus_rdata = rx_base[ring];
      SEL_RXPTR:  bus_rdata = rx_ptr[ring];
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_ring_regs_chk.sv
module dma_ring_regs_chk
  import dma_ring_regs_pkg::*;
#(
  parameter int NRING = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [WIDX_W-1:0] bus_word,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       evt_set,
  input logic [31:0]       evt_q,
  input logic [31:0]       ena_q,
  input logic [NRING-1:0]  tx_kick,
  input logic [NRING-1:0]  rx_kick,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              irq_err
);

  // R1: kick outputs stay low while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (tx_kick == '0 && rx_kick == '0)
        else $error("kick active during reset");
    end
  end

  assert_tx_kick_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_kick != '0) |-> $past(bus_wr && bus_word == W_TXH));

  assert_rx_kick_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_kick != '0) |-> $past(bus_wr && bus_word == W_RXH));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !(irq_tx || irq_rx || irq_err));

  assert_wo_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word == W_CMD) |-> (bus_rdata == '0));

  assert_ring_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_word[WIDX_W-1:6] == 4'h1) |-> (bus_rdata[2:0] == 3'b000));

endmodule

bind dma_ring_regs dma_ring_regs_chk #(.NRING(NRING)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_word  (bus_addr[11:2]),
  .bus_rdata (bus_rdata),
  .evt_set   (evt_set),
  .evt_q     (evt_q),
  .ena_q     (ena_q),
  .tx_kick   (tx_kick),
  .rx_kick   (rx_kick),
  .irq_tx    (irq_tx),
  .irq_rx    (irq_rx),
  .irq_err   (irq_err)
);

// File: tb/sim_dma_ring_regs.sv
module sim_dma_ring_regs;

  localparam logic [31:0] IDV = 32'h5A10_0008;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_set = '0;
  logic [7:0]  tx_halt_set = '0;
  logic [7:0]  rx_halt_set = '0;
  logic [31:0] cmd_word;
  logic [7:0]  tx_kick, rx_kick;
  logic        irq_tx, irq_rx, irq_err;

  always #10 clk = ~clk;

  dma_ring_regs u0 (
    .clk (clk), .rst_n (rst_n),
    .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .evt_set (evt_set),
    .tx_halt_set (tx_halt_set), .rx_halt_set (rx_halt_set),
    .cmd_word (cmd_word), .tx_kick (tx_kick), .rx_kick (rx_kick),
    .irq_tx (irq_tx), .irq_rx (irq_rx), .irq_err (irq_err)
  );

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard: 0 rdata, 1 tx_kick, 2 rx_kick, 3 irq {tx,rx,err}, 4 cmd_word
  int          q_sel[$];
  logic [31:0] q_exp[$];
  int          q_due[$];
  string       q_tag[$];

  task automatic push(input int s, input logic [31:0] e, input string t);
    q_sel.push_back(s);
    q_exp.push_back(e);
    q_due.push_back(cyc);
    q_tag.push_back(t);
  endtask

  always @(negedge clk) begin
    int s;
    logic [31:0] e;
    logic [31:0] a;
    string t;
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      s = q_sel.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      case (s)
        0: a = bus_rdata;
        1: a = {24'b0, tx_kick};
        2: a = {24'b0, rx_kick};
        3: a = {29'b0, irq_tx, irq_rx, irq_err};
        default: a = cmd_word;
      endcase
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    tick();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    tick();
    bus_addr = a;
    push(0, e, t);
  endtask

  task automatic obs(input int s, input logic [31:0] e, input string t);
    push(s, e, t);
  endtask

  task automatic pulse(input logic [31:0] ev, input logic [7:0] th, input logic [7:0] rh);
    tick();
    evt_set = ev; tx_halt_set = th; rx_halt_set = rh;
    tick();
    evt_set = '0; tx_halt_set = '0; rx_halt_set = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset values
    obs(3, 32'h0, "R1 irq after reset");
    obs(1, 32'h0, "R1 tx_kick after reset");
    obs(4, 32'h0, "R1 cmd_word after reset");
    rd(12'h000, 32'h0, "R1 event reset");
    rd(12'h004, 32'h0, "R1 enable reset");
    rd(12'h008, IDV,   "R1 identity reset");
    rd(12'h010, 32'h0, "R1 tx halt reset");

    // R3: read-write enable
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 32'hFFFF_FFFF, "R3 enable readback");
    wr(12'h004, 32'h0);

    // R6/R7: hardware set while masked, then enable per group
    pulse(32'h0000_0100, 8'h0, 8'h0);
    obs(3, 32'h0, "R7 masked event gives no irq");
    rd(12'h000, 32'h0000_0100, "R6 event set by strobe");
    wr(12'h004, 32'h0000_0100);
    obs(3, 32'h2, "R7 rx group irq");
    wr(12'h004, 32'h0001_0100);
    pulse(32'h0001_0000, 8'h0, 8'h0);
    obs(3, 32'h3, "R7 rx and err irq");
    wr(12'h000, 32'h0000_0100);
    obs(3, 32'h1, "R7 err only after clear");
    rd(12'h000, 32'h0001_0000, "R6 write-1 clears one bit");

    // R6: set and clear of the same bit in one cycle
    tick();
    evt_set = 32'h4; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h0001_0004;
    tick();
    evt_set = '0; bus_wr = 1'b0;
    rd(12'h000, 32'h0000_0004, "R6 set wins over clear");
    obs(3, 32'h0, "R7 bit outside enable");
    wr(12'h004, 32'h0000_0004);
    obs(3, 32'h4, "R7 tx group irq");

    // R4: write-only command
    wr(12'h00C, 32'hCAFE_F00D);
    obs(4, 32'hCAFE_F00D, "R4 cmd_word output");
    rd(12'h00C, 32'h0, "R4 write-only reads zero");

    // R5: read-only identity
    wr(12'h008, 32'h0);
    rd(12'h008, IDV, "R5 identity unchanged");

    // R2: unmapped word and misaligned address
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h800, 32'h0, "R2 unmapped reads zero");
    rd(12'h002, 32'h0000_0004, "R2 low address bits ignored");

    // R10/R8: transmit halt flags and kicks
    pulse(32'h0, 8'h24, 8'h0);
    rd(12'h010, 32'h2400_0000, "R10 tx halt set rings 2 and 5");
    wr(12'h010, 32'h2100_0000);
    obs(1, 32'h0000_0084, "R8 kick rings 2 and 7");
    tick();
    obs(1, 32'h0, "R8 kick lasts one cycle");
    rd(12'h010, 32'h0400_0000, "R10 tx halt ring 2 cleared");

    // R9/R10: receive kicks only where flag was clear
    pulse(32'h0, 8'h0, 8'h02);
    rd(12'h014, 32'h0040_0000, "R10 rx halt set ring 1");
    wr(12'h014, 32'h0050_0000);
    obs(2, 32'h0000_0008, "R9 kick ring 3 only");
    obs(1, 32'h0, "R8 no tx kick from rx write");
    rd(12'h014, 32'h0, "R10 rx halt ring 1 cleared");

    // R11/R12: bases, pointers
    wr(12'h108, 32'h1234_567F);
    rd(12'h108, 32'h1234_5678, "R11 tx base aligned");
    rd(12'h148, 32'h1234_5678, "R11 tx pointer copied");
    wr(12'h194, 32'hFFFF_FFFF);
    rd(12'h194, 32'hFFFF_FFF8, "R11 rx base aligned");
    rd(12'h1D4, 32'hFFFF_FFF8, "R11 rx pointer copied");
    rd(12'h1D0, 32'h0, "R11 other ring untouched");
    wr(12'h148, 32'h0);
    rd(12'h148, 32'h1234_5678, "R12 pointer write ignored");

    repeat (3) tick();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule